// File: doc/BRIEF.md
# Four-Beat Burst Address Generator

This block supplies the access address for each cycle of a short burst into a synchronous memory. On a load cycle it captures the whole external address. That captured value becomes the first address of the burst. On each continue cycle, a two-bit beat counter moves forward. Only the two lowest address bits are then rebuilt from the captured start bits and the beat count. The bits above them keep the captured value for the whole burst.

A static order-select input picks between two patterns for the low bits:

- **Wrapping increment:** the low bits are the start bits plus the beat count, modulo 4.
- **Interleaved:** the low bits are the start bits XOR the beat count.

In both modes the fifth address of a burst equals the first. An active-low clock enable freezes all state.

The block does not look at which command is running. Every enabled cycle with the advance flag high moves the counter. This includes cycles that access nothing, such as dummy reads and aborted writes. The address path is plain control, with no valid/ready handshake. The address belongs to whichever cycle the surrounding command logic is running, so there is no back-pressure to apply.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `acc_addr` is all zeros.
- R2: A cycle with `ce_n` low and `adv` low makes `acc_addr` equal to that cycle's `ext_addr` after the clock edge.
- R3: On enabled cycles with `adv` high, bits `ADDR_W-1` down to 2 of `acc_addr` keep the value loaded at the start of the burst.
- R4: With `order_sel` = 0 (wrapping increment), `acc_addr[1:0]` equals the loaded low bits plus the number of advances since the load, modulo 4. For example, start 1 gives 1,2,3,0.
- R5: With `order_sel` = 1 (interleaved), `acc_addr[1:0]` equals the loaded low bits XOR the number of advances modulo 4. For example, start 2 gives 2,3,0,1 and start 3 gives 3,2,1,0.
- R6: The fourth advance after a load returns `acc_addr` to the loaded address, in both orders.
- R7: While `ce_n` is high, `acc_addr` does not change, whatever `adv` and `ext_addr` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Clock enable, active low; high holds all state |
| adv | input | 1 | 1 = advance the burst, 0 = load `ext_addr` |
| order_sel | input | 1 | Burst order: 0 = wrapping increment, 1 = interleaved |
| ext_addr | input | ADDR_W | External address captured on load cycles |
| acc_addr | output | ADDR_W | Access address for the current cycle |

## Verification
The bench builds the block with `ADDR_W` = 10. That is wide enough to show eight upper bits staying frozen through a burst, while every one of the four low-bit start values can be loaded under both orders. This width makes full wrap-around in both orders reachable in short vector runs. It also reaches loads of all-ones and mixed patterns, and clock-enable stalls placed in the middle of a burst.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEAT_W = 2;

  typedef enum logic {
    ORD_WRAP  = 1'b0,
    ORD_XOR   = 1'b1
  } burst_order_e;

  typedef logic [BEAT_W-1:0] beat_t;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ce_n,
  input  logic  adv,
  output beat_t beat
);
  beat_t beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else if (!ce_n) begin
      if (adv) beat_q <= beat_q + beat_t'(1);
      else     beat_q <= '0;
    end
  end

  assign beat = beat_q;
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              adv,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] base
);
  logic [ADDR_W-1:0] base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              base_q <= '0;
    else if (!ce_n && !adv)  base_q <= ext_addr;
  end

  assign base = base_q;
endmodule

// File: rtl/burst_low_map.sv
module burst_low_map
  import burst_pkg::*;
(
  input  beat_t        start,
  input  beat_t        beat,
  input  burst_order_e order,
  output beat_t        low
);
  beat_t wrap_low;
  beat_t xor_low;

  assign wrap_low = start + beat;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
    assign xor_low[b] = start[b] ^ beat[b];
  end

  always_comb begin
    unique case (order)
      ORD_XOR:  low = xor_low;
      default:  low = wrap_low;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              adv,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] acc_addr
);
  localparam int HI_W = ADDR_W - BEAT_W;

  beat_t             beat;
  beat_t             low;
  logic [ADDR_W-1:0] base;
  burst_order_e      order;

  assign order = burst_order_e'(order_sel);

  burst_beat_ctr u_beat (
    .clk   (clk),
    .rst_n (rst_n),
    .ce_n  (ce_n),
    .adv   (adv),
    .beat  (beat)
  );

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .adv      (adv),
    .ext_addr (ext_addr),
    .base     (base)
  );

  burst_low_map u_map (
    .start (base[BEAT_W-1:0]),
    .beat  (beat),
    .order (order),
    .low   (low)
  );

  if (HI_W > 0) begin : g_hi
    assign acc_addr = {base[ADDR_W-1:BEAT_W], low};
  end else begin : g_lo_only
    assign acc_addr = low;
  end
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              adv,
  input logic              order_sel,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] acc_addr
);
  logic [1:0] m_start;
  logic [1:0] m_cnt;
  logic [1:0] wrap_exp;
  logic [1:0] xor_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_start <= '0;
      m_cnt   <= '0;
    end else if (!ce_n) begin
      if (!adv) begin
        m_start <= ext_addr[1:0];
        m_cnt   <= '0;
      end else begin
        m_cnt <= m_cnt + 2'd1;
      end
    end
  end

  assign wrap_exp = m_start + m_cnt;
  assign xor_exp  = m_start ^ m_cnt;

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !adv) |=> (acc_addr == $past(ext_addr))); // R2

  AST_UPPER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && adv) |=> (acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2]))); // R3

  AST_WRAP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    !order_sel |-> (acc_addr[1:0] == wrap_exp)); // R4

  AST_XOR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    order_sel |-> (acc_addr[1:0] == xor_exp)); // R5

  AST_WRAP_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && adv && (m_cnt == 2'd3)) |=> (acc_addr[1:0] == m_start)); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && $stable(order_sel)) |=> ($stable(acc_addr) || !$stable(order_sel))); // R7
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (ce_n),
  .adv       (adv),
  .order_sel (order_sel),
  .ext_addr  (ext_addr),
  .acc_addr  (acc_addr)
);

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
  localparam int AW = 10;

  typedef struct packed {
    logic          ce_n;
    logic          adv;
    logic          ord;
    logic [AW-1:0] ext;
    logic [AW-1:0] exp;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b0, 10'h2A5, 10'h2A5},  // R2 load, start 01
    '{1'b0, 1'b1, 1'b0, 10'h000, 10'h2A6},  // R4 R3
    '{1'b0, 1'b1, 1'b0, 10'h3FF, 10'h2A7},  // R4
    '{1'b0, 1'b1, 1'b0, 10'h000, 10'h2A4},  // R4 wraps low
    '{1'b0, 1'b1, 1'b0, 10'h000, 10'h2A5},  // R6 fifth address
    '{1'b1, 1'b1, 1'b0, 10'h111, 10'h2A5},  // R7 stall on advance
    '{1'b1, 1'b0, 1'b0, 10'h111, 10'h2A5},  // R7 stall on load
    '{1'b0, 1'b0, 1'b1, 10'h13E, 10'h13E},  // R2 load, start 10
    '{1'b0, 1'b1, 1'b1, 10'h000, 10'h13F},  // R5
    '{1'b0, 1'b1, 1'b1, 10'h000, 10'h13C},  // R5
    '{1'b0, 1'b1, 1'b1, 10'h000, 10'h13D},  // R5
    '{1'b0, 1'b1, 1'b1, 10'h000, 10'h13E},  // R6
    '{1'b0, 1'b0, 1'b1, 10'h0F3, 10'h0F3},  // R2 load, start 11
    '{1'b0, 1'b1, 1'b1, 10'h000, 10'h0F2},  // R5 3-2-1-0
    '{1'b0, 1'b1, 1'b1, 10'h000, 10'h0F1},  // R5
    '{1'b0, 1'b1, 1'b1, 10'h000, 10'h0F0},  // R5
    '{1'b0, 1'b1, 1'b1, 10'h000, 10'h0F3},  // R6
    '{1'b0, 1'b0, 1'b0, 10'h3FF, 10'h3FF},  // R2 all ones
    '{1'b0, 1'b1, 1'b0, 10'h000, 10'h3FC},  // R4 R3
    '{1'b1, 1'b0, 1'b0, 10'h155, 10'h3FC},  // R7 mid-burst stall
    '{1'b0, 1'b1, 1'b0, 10'h155, 10'h3FD},  // R4 resumes
    '{1'b0, 1'b0, 1'b1, 10'h200, 10'h200},  // R2 load, start 00
    '{1'b0, 1'b1, 1'b1, 10'h000, 10'h201},  // R5
    '{1'b0, 1'b1, 1'b1, 10'h000, 10'h202},  // R5
    '{1'b0, 1'b0, 1'b1, 10'h081, 10'h081},  // R2 reload mid-burst, start 01
    '{1'b0, 1'b1, 1'b1, 10'h000, 10'h080},  // R5 1-0-3-2
    '{1'b0, 1'b1, 1'b1, 10'h000, 10'h083}   // R5
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1;
  logic          adv = 1'b0;
  logic          order_sel = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] acc_addr;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) i_burst_addr_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .adv       (adv),
    .order_sel (order_sel),
    .ext_addr  (ext_addr),
    .acc_addr  (acc_addr)
  );

  task automatic check(input string req, input logic [AW-1:0] exp);
    n_run++;
    if (acc_addr !== exp) begin
      n_fail++;
      $display("FAIL %s: acc_addr=%h expected=%h", req, acc_addr, exp);
    end
  endtask

  task automatic step(input logic c, input logic a, input logic o, input logic [AW-1:0] e);
    @(negedge clk);
    ce_n = c; adv = a; order_sel = o; ext_addr = e;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #20000;
    n_fail++;
    $display("FAIL watchdog: acc_addr=%h expected=completion", acc_addr);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", '0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].ce_n, VEC[i].adv, VEC[i].ord, VEC[i].ext);
      check($sformatf("vector %0d (R2..R7)", i), VEC[i].exp);
    end

    // R1: reset in the middle of a burst
    step(1'b0, 1'b0, 1'b0, 10'h1C6);
    step(1'b0, 1'b1, 1'b0, 10'h000);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 mid-burst", '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R6: full cycle for every start value, both orders
    for (int o = 0; o < 2; o++) begin
      for (int s = 0; s < 4; s++) begin
        step(1'b0, 1'b0, o[0], AW'(10'h340 | s));
        for (int k = 1; k <= 4; k++) begin
          step(1'b0, 1'b1, o[0], '0);
          if (o == 0)
            check("R4/R6 sweep", AW'(10'h340 | ((s + k) % 4)));
          else
            check("R5/R6 sweep", AW'(10'h340 | (s ^ (k % 4))));
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule